// File: doc/BRIEF.md
# Infrared receiver run-length sampler

This block is the receive front end for a consumer infrared link. It takes the output of an IR demodulator, resynchronises it, can flip its polarity, and samples it on a slow tick of one sample per `TICK_DIV` clocks (64 by default). Level changes that do not last longer than a programmable noise threshold are treated as glitches and absorbed into the run around them. Each clean run of constant level becomes one byte: a level bit and a length count. These bytes go into a receive FIFO whose depth is a parameter.

When the line has rested at the inactive level for longer than a programmable idle threshold, the pending space run is flushed and a packet-end flag is raised. Nothing more is recorded until the next active run. Three sticky flags (overflow, packet end, data available) can each be routed to a single interrupt output.

Software configures the block, reads status and empties the FIFO through a small word-addressed register port. Protocol decoding is left to software.

Top module: `ir_rx_sampler`

Register word offsets (byte address bits 4:2; all other address bits must be zero):

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | receive configuration |
| 0x08 | sample configuration |
| 0x0C | interrupt enable |
| 0x10 | status |
| 0x14 | FIFO data |

## Requirements
- R1: After reset, every register reads 0, and so do the status flags, the FIFO count and `irq`.
- R2: Sampling runs only while control bit 0 (global enable) and bit 1 (receive enable) are both 1 and control bits 5:4 equal 2'b11. In any other setting no entries are produced.
- R3: A sample tick occurs every `TICK_DIV` clocks. A run of N ticks (1 to 128) is stored as one byte. Bit 7 of the byte is the run's level (1 = active, 0 = space) and bits 6:0 hold N-1.
- R4: When receive-configuration bit 2 is 0, `ir_in` high is the active level. When it is 1, the input is inverted, so `ir_in` low is active.
- R5: A run longer than 128 ticks first produces an entry with count 0x7F and then keeps counting at the same level. A run of 200 ticks therefore gives 0x7F and then 71 (low bits). A run of exactly 128 ticks gives a single 0x7F entry.
- R6: Sample-configuration bits 7:2 hold the noise threshold T. A level change that lasts T ticks or fewer is absorbed into the surrounding run. A change that lasts T+1 ticks is accepted, and the stored run lengths are unchanged by the filter.
- R7: Sample-configuration bits 15:8 hold the idle threshold I. When a space reaches I+1 ticks, the entry {0, I} is pushed and status bit 1 (packet end) is set. After that, no entry is produced until the next active level. A space seen right after enabling is not recorded.
- R8: A read of the FIFO data register returns the oldest entry and removes it. A read of an empty FIFO returns 0 and changes nothing. Status bits from bit 8 upward hold the fill count.
- R9: A push into a full FIFO discards the entry and sets status bit 0 (overflow).
- R10: Status bit 4 (data available) is set while the fill count is greater than the trigger level held in interrupt-enable bits from bit 8 upward.
- R11: Writing 1 to status bit 0, 1 or 4 clears that flag. Writing 0 leaves the flag as it is. A flag whose set condition is still true stays set.
- R12: `irq` is high when any status flag is set together with its enable bit at the same position (0, 1 or 4) in the interrupt-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Raw demodulated IR line, asynchronous |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; a FIFO data read pops |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume a synchronous reset held for at least one clock, and read and write strobes that last exactly one cycle for each access. They also assume that the enable bits are not toggled within a tick of a push that matters to a check. The stimulus meets these assumptions by driving the bus from tasks that pulse each strobe for one cycle at the falling edge. It changes the polarity only while sampling is disabled. It holds every `ir_in` level for a whole multiple of the tick length, so the number of samples in each run is fixed whatever the tick phase.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

   // Entry layout: level bit on top, (run length - 1) below it
   localparam int unsigned LEN_W   = 7;
   localparam int unsigned ENTRY_W = LEN_W + 1;
   localparam int unsigned MAX_RUN = 1 << LEN_W;
   localparam int unsigned REG_W   = 32;

   // Threshold field widths
   localparam int unsigned NTHR_W = 6;
   localparam int unsigned ITHR_W = 8;

   // Word indices of the register map
   localparam logic [2:0] IDX_CTRL  = 3'd0;
   localparam logic [2:0] IDX_RXCFG = 3'd1;
   localparam logic [2:0] IDX_SAMP  = 3'd2;
   localparam logic [2:0] IDX_INTEN = 3'd3;
   localparam logic [2:0] IDX_STAT  = 3'd4;
   localparam logic [2:0] IDX_FIFO  = 3'd5;

   // Bit positions
   localparam int unsigned B_GEN  = 0;
   localparam int unsigned B_RXEN = 1;
   localparam int unsigned B_MODE = 4;
   localparam int unsigned B_INV  = 2;
   localparam int unsigned B_NTHR = 2;
   localparam int unsigned B_ITHR = 8;
   localparam int unsigned B_OVF  = 0;
   localparam int unsigned B_PE   = 1;
   localparam int unsigned B_DA   = 4;
   localparam int unsigned B_LVL  = 8;
   localparam int unsigned B_CNT  = 8;

   localparam logic [1:0] MODE_RX = 2'b11;

   typedef struct packed {
      logic             lvl;
      logic [LEN_W-1:0] len_m1;
   } run_entry_t;

endpackage

// File: rtl/ir_rx_front.sv
module ir_rx_front
   import ir_rx_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              invert,
   input  logic              ir_in,
   input  logic [NTHR_W-1:0] noise_thr,
   output logic              stb,
   output logic              level
);

   localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

   if (TICK_DIV < 2) begin : g_div_chk
      $error("ir_rx_front: TICK_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_sync_chk
      $error("ir_rx_front: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [DIV_W-1:0]       div_q;
   logic [NTHR_W-1:0]      glitch_q;
   logic                   flt_q;
   logic                   stb_q;
   logic                   tick;
   logic                   sample;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
      end
   end

   assign sample = sync_q[SYNC_STAGES-1] ^ invert;
   assign tick   = (div_q == DIV_LAST);

   // Glitch filter: a new level is taken on its (noise_thr+1)-th
   // consecutive differing sample, so every edge moves by the same delay
   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         div_q    <= '0;
         glitch_q <= '0;
         flt_q    <= 1'b0;
         stb_q    <= 1'b0;
      end else begin
         stb_q <= tick;
         div_q <= tick ? '0 : div_q + 1'b1;
         if (tick) begin
            if (sample == flt_q) begin
               glitch_q <= '0;
            end else if (glitch_q >= noise_thr) begin
               flt_q    <= sample;
               glitch_q <= '0;
            end else begin
               glitch_q <= glitch_q + 1'b1;
            end
         end
      end
   end

   assign stb   = stb_q;
   assign level = flt_q;

endmodule

// File: rtl/ir_rx_runlen.sv
module ir_rx_runlen
   import ir_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stb,
   input  logic              level,
   input  logic [ITHR_W-1:0] idle_thr,
   output logic              push,
   output run_entry_t        entry,
   output logic              pkt_end
);

   localparam int unsigned LCNT_W = LEN_W + 1;
   localparam int unsigned ICNT_W = ITHR_W + 1;
   localparam logic [LCNT_W-1:0] LEN_MAX = LCNT_W'(MAX_RUN);

   logic              idle_q, idle_n;
   logic              cur_q, cur_n;
   logic [LCNT_W-1:0] len_q, len_n;
   logic [ICNT_W-1:0] icnt_q, icnt_n;
   logic [ICNT_W-1:0] icnt_inc;
   logic [LCNT_W-1:0] len_dec;
   logic [LEN_W-1:0]  flush_len;
   logic              idle_hit;

   assign icnt_inc  = icnt_q + 1'b1;
   assign len_dec   = len_q - 1'b1;
   assign idle_hit  = !cur_q && (icnt_inc > {1'b0, idle_thr});
   assign flush_len = (len_q == LEN_MAX) ? '1 : len_q[LEN_W-1:0];

   always_comb begin
      idle_n  = idle_q;
      cur_n   = cur_q;
      len_n   = len_q;
      icnt_n  = icnt_q;
      push    = 1'b0;
      pkt_end = 1'b0;
      entry   = '0;
      if (stb) begin
         if (idle_q) begin
            if (level) begin
               idle_n = 1'b0;
               cur_n  = 1'b1;
               len_n  = LCNT_W'(1);
               icnt_n = '0;
            end
         end else if (level != cur_q) begin
            push         = 1'b1;
            entry.lvl    = cur_q;
            entry.len_m1 = len_dec[LEN_W-1:0];
            cur_n        = level;
            len_n        = LCNT_W'(1);
            icnt_n       = level ? '0 : ICNT_W'(1);
         end else if (idle_hit) begin
            push         = 1'b1;
            pkt_end      = 1'b1;
            entry.lvl    = 1'b0;
            entry.len_m1 = flush_len;
            idle_n       = 1'b1;
            len_n        = '0;
            icnt_n       = '0;
         end else if (len_q == LEN_MAX) begin
            push         = 1'b1;
            entry.lvl    = cur_q;
            entry.len_m1 = '1;
            len_n        = LCNT_W'(1);
            icnt_n       = cur_q ? '0 : icnt_inc;
         end else begin
            len_n  = len_q + 1'b1;
            icnt_n = cur_q ? '0 : icnt_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         idle_q <= 1'b1;
         cur_q  <= 1'b0;
         len_q  <= '0;
         icnt_q <= '0;
      end else begin
         idle_q <= idle_n;
         cur_q  <= cur_n;
         len_q  <= len_n;
         icnt_q <= icnt_n;
      end
   end

endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   if (DEPTH != 16 && DEPTH != 64) begin : g_depth_chk
      $error("ir_rx_fifo: DEPTH must be 16 or 64");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr_q;
   logic [AW-1:0]    rptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push;
   logic             do_pop;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wptr_q] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rdata = mem[rptr_q];
   assign count = cnt_q;

endmodule

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler
   import ir_rx_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned TICK_DIV   = 64,
   parameter int unsigned ADDR_W     = 5,
   localparam int unsigned LVL_W = $clog2(FIFO_DEPTH),
   localparam int unsigned CNT_W = LVL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              irq
);

   if (ADDR_W < 5) begin : g_addr_chk
      $error("ir_rx_sampler: ADDR_W must be at least 5");
   end

   // Configuration state
   logic              gen_q, rxen_q;
   logic [1:0]        mode_q;
   logic              inv_q;
   logic [NTHR_W-1:0] nthr_q;
   logic [ITHR_W-1:0] ithr_q;
   logic              ie_ovf_q, ie_pe_q, ie_da_q;
   logic [LVL_W-1:0]  trig_q;

   // Sticky flags
   logic ovf_q, pe_q, da_q;

   // Decode
   logic       addr_ok;
   logic [2:0] idx;
   logic       wr_ctrl, wr_rxcfg, wr_samp, wr_inten, wr_stat;
   logic       run_en;

   assign addr_ok  = ((bus_addr >> 5) == '0);
   assign idx      = bus_addr[4:2];
   assign wr_ctrl  = bus_wr && addr_ok && (idx == IDX_CTRL);
   assign wr_rxcfg = bus_wr && addr_ok && (idx == IDX_RXCFG);
   assign wr_samp  = bus_wr && addr_ok && (idx == IDX_SAMP);
   assign wr_inten = bus_wr && addr_ok && (idx == IDX_INTEN);
   assign wr_stat  = bus_wr && addr_ok && (idx == IDX_STAT);
   assign run_en   = gen_q && rxen_q && (mode_q == MODE_RX);

   // Datapath
   logic                fe_stb, fe_level;
   logic                rl_push, rl_pkt_end;
   run_entry_t          rl_entry;
   logic                fifo_pop, fifo_full, fifo_empty;
   logic [ENTRY_W-1:0]  fifo_head;
   logic [CNT_W-1:0]    fifo_cnt;

   ir_rx_front #(
      .TICK_DIV    (TICK_DIV),
      .SYNC_STAGES (2)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (run_en),
      .invert    (inv_q),
      .ir_in     (ir_in),
      .noise_thr (nthr_q),
      .stb       (fe_stb),
      .level     (fe_level)
   );

   ir_rx_runlen u_runlen (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run_en),
      .stb      (fe_stb),
      .level    (fe_level),
      .idle_thr (ithr_q),
      .push     (rl_push),
      .entry    (rl_entry),
      .pkt_end  (rl_pkt_end)
   );

   assign fifo_pop = bus_rd && addr_ok && (idx == IDX_FIFO) && !fifo_empty;

   ir_rx_fifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (ENTRY_W)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rl_push),
      .wdata (rl_entry),
      .pop   (fifo_pop),
      .rdata (fifo_head),
      .count (fifo_cnt),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   // Configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_q    <= 1'b0;
         rxen_q   <= 1'b0;
         mode_q   <= 2'b00;
         inv_q    <= 1'b0;
         nthr_q   <= '0;
         ithr_q   <= '0;
         ie_ovf_q <= 1'b0;
         ie_pe_q  <= 1'b0;
         ie_da_q  <= 1'b0;
         trig_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            gen_q  <= bus_wdata[B_GEN];
            rxen_q <= bus_wdata[B_RXEN];
            mode_q <= bus_wdata[B_MODE +: 2];
         end
         if (wr_rxcfg) begin
            inv_q <= bus_wdata[B_INV];
         end
         if (wr_samp) begin
            nthr_q <= bus_wdata[B_NTHR +: NTHR_W];
            ithr_q <= bus_wdata[B_ITHR +: ITHR_W];
         end
         if (wr_inten) begin
            ie_ovf_q <= bus_wdata[B_OVF];
            ie_pe_q  <= bus_wdata[B_PE];
            ie_da_q  <= bus_wdata[B_DA];
            trig_q   <= bus_wdata[B_LVL +: LVL_W];
         end
      end
   end

   // Sticky flags: a set in the same cycle wins over a clear
   logic ovf_set, pe_set, da_set;
   logic ovf_clr, pe_clr, da_clr;

   assign ovf_set = rl_push && fifo_full;
   assign pe_set  = rl_pkt_end;
   assign da_set  = (fifo_cnt > {1'b0, trig_q});
   assign ovf_clr = wr_stat && bus_wdata[B_OVF];
   assign pe_clr  = wr_stat && bus_wdata[B_PE];
   assign da_clr  = wr_stat && bus_wdata[B_DA];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         pe_q  <= 1'b0;
         da_q  <= 1'b0;
      end else begin
         ovf_q <= (ovf_q && !ovf_clr) || ovf_set;
         pe_q  <= (pe_q  && !pe_clr)  || pe_set;
         da_q  <= (da_q  && !da_clr)  || da_set;
      end
   end

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && addr_ok) begin
         case (idx)
            IDX_CTRL: begin
               bus_rdata[B_GEN]       = gen_q;
               bus_rdata[B_RXEN]      = rxen_q;
               bus_rdata[B_MODE +: 2] = mode_q;
            end
            IDX_RXCFG: bus_rdata[B_INV] = inv_q;
            IDX_SAMP: begin
               bus_rdata[B_NTHR +: NTHR_W] = nthr_q;
               bus_rdata[B_ITHR +: ITHR_W] = ithr_q;
            end
            IDX_INTEN: begin
               bus_rdata[B_OVF]         = ie_ovf_q;
               bus_rdata[B_PE]          = ie_pe_q;
               bus_rdata[B_DA]          = ie_da_q;
               bus_rdata[B_LVL +: LVL_W] = trig_q;
            end
            IDX_STAT: begin
               bus_rdata[B_OVF]          = ovf_q;
               bus_rdata[B_PE]           = pe_q;
               bus_rdata[B_DA]           = da_q;
               bus_rdata[B_CNT +: CNT_W] = fifo_cnt;
            end
            IDX_FIFO: begin
               if (!fifo_empty) bus_rdata[ENTRY_W-1:0] = fifo_head;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   assign irq = (ovf_q && ie_ovf_q) || (pe_q && ie_pe_q) || (da_q && ie_da_q);

endmodule

// File: rtl/ir_rx_sampler_chk.sv
module ir_rx_sampler_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             push,
   input logic             push_lvl,
   input logic             full,
   input logic             pop,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             pe_flag
);

   // R8
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R8
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(count));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> ovf_flag);

   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !$past(run_en)) |-> !push);

   // R7
   pe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pe_flag) |-> ($past(push) && !$past(push_lvl)));

endmodule

bind ir_rx_sampler ir_rx_sampler_chk #(
   .DEPTH (FIFO_DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .push     (rl_push),
   .push_lvl (rl_entry.lvl),
   .full     (fifo_full),
   .pop      (fifo_pop),
   .count    (fifo_cnt),
   .ovf_flag (ovf_q),
   .pe_flag  (pe_q)
);

// File: tb/ir_rx_sampler_tb.sv
module ir_rx_sampler_tb;

   localparam int unsigned DEP  = 16;
   localparam int unsigned DIV  = 8;
   localparam int unsigned AW   = 5;
   localparam int unsigned CW   = 5;

   localparam logic [AW-1:0] A_CTRL  = 5'h00;
   localparam logic [AW-1:0] A_RXCFG = 5'h04;
   localparam logic [AW-1:0] A_SAMP  = 5'h08;
   localparam logic [AW-1:0] A_INTEN = 5'h0C;
   localparam logic [AW-1:0] A_STAT  = 5'h10;
   localparam logic [AW-1:0] A_FIFO  = 5'h14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ir_in = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int vectors = 0;
   int miscompares = 0;
   int exp_q[$];

   always #5 clk = ~clk;

   ir_rx_sampler #(
      .FIFO_DEPTH (DEP),
      .TICK_DIV   (DIV),
      .ADDR_W     (AW)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ir_in     (ir_in),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic run(input logic lvl, input int ticks);
      ir_in = lvl;
      repeat (ticks * DIV) @(negedge clk);
   endtask

   function automatic logic [31:0] cnt_of(input logic [31:0] st);
      return 32'(st[8 +: CW]);
   endfunction

   // Compare FIFO contents with exp_q, then empty exp_q
   task automatic drain(input string req);
      logic [31:0] st;
      logic [31:0] d;
      rd(A_STAT, st);
      chk({req, " count"}, cnt_of(st), 32'(exp_q.size()));
      for (int i = 0; i < exp_q.size(); i++) begin
         rd(A_FIFO, d);
         chk({req, " entry"}, d, 32'(exp_q[i]));
      end
      exp_q.delete();
   endtask

   initial begin
      logic [31:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
      rd(A_RXCFG, d); chk("R1 rxcfg", d, 0);
      rd(A_SAMP, d);  chk("R1 samp", d, 0);
      rd(A_INTEN, d); chk("R1 inten", d, 0);
      rd(A_STAT, d);  chk("R1 stat", d, 0);
      rd(A_FIFO, d);  chk("R1 fifo", d, 0);
      chk("R1 irq", 32'(irq), 0);

      // R2: partial enables record nothing
      wr(A_SAMP, (0 << 2) | (20 << 8));
      wr(A_CTRL, 32'h03);
      run(1, 4); run(0, 30);
      rd(A_STAT, d); chk("R2 mode off", cnt_of(d), 0);
      wr(A_CTRL, 32'h31);
      run(1, 4); run(0, 30);
      rd(A_STAT, d); chk("R2 rx off", cnt_of(d), 0);
      wr(A_CTRL, 32'h33);

      // R3 sweep of run lengths, R7 idle flush, R11 clear
      for (int p = 1; p <= 6; p++) begin
         run(0, 3);
         run(1, p); run(0, p + 2); run(1, 7 - p); run(0, 30);
         exp_q.push_back(32'h80 | (p - 1));
         exp_q.push_back(p + 1);
         exp_q.push_back(32'h80 | (6 - p));
         exp_q.push_back(20);
         if (p == 1) begin
            run(0, 40);
            rd(A_STAT, d); chk("R7 quiet after end", cnt_of(d), 4);
         end
         rd(A_STAT, d); chk("R7 packet end", 32'(d[1]), 1);
         drain("R3 sweep");
         wr(A_STAT, 32'h02);
         rd(A_STAT, d); chk("R11 pe cleared", 32'(d[1]), 0);
      end

      // R4 polarity inversion
      wr(A_CTRL, 0);
      wr(A_RXCFG, 32'h4);
      ir_in = 1'b1;
      wr(A_CTRL, 32'h33);
      run(1, 5); run(0, 4); run(1, 30);
      exp_q.push_back(32'h83);
      exp_q.push_back(20);
      drain("R4 invert");
      wr(A_CTRL, 0);
      wr(A_RXCFG, 0);
      ir_in = 1'b0;
      wr(A_CTRL, 32'h33);

      // R5 saturation
      run(1, 200); run(0, 30);
      exp_q.push_back(32'hFF);
      exp_q.push_back(32'h80 | 71);
      exp_q.push_back(20);
      drain("R5 long");
      run(1, 128); run(0, 30);
      exp_q.push_back(32'hFF);
      exp_q.push_back(20);
      drain("R5 exact");

      // R6 glitch filter, threshold 2
      wr(A_SAMP, (2 << 2) | (20 << 8));
      run(1, 5); run(0, 2); run(1, 4); run(0, 3); run(1, 3); run(0, 30);
      exp_q.push_back(32'h80 | 10);
      exp_q.push_back(2);
      exp_q.push_back(32'h82);
      exp_q.push_back(20);
      drain("R6 glitch");
      run(1, 2); run(0, 30);
      rd(A_STAT, d); chk("R6 idle glitch", cnt_of(d), 0);
      wr(A_SAMP, (0 << 2) | (20 << 8));
      wr(A_STAT, 32'h13);

      // R10 trigger level
      wr(A_INTEN, 4 << 8);
      run(1, 2); run(0, 2); run(1, 2); run(0, 30);
      rd(A_STAT, d); chk("R10 count 4 trig 4", 32'(d[4]), 0);
      wr(A_INTEN, 3 << 8);
      rd(A_STAT, d); chk("R10 count 4 trig 3", 32'(d[4]), 1);
      exp_q.push_back(32'h81); exp_q.push_back(1);
      exp_q.push_back(32'h81); exp_q.push_back(20);
      drain("R10 entries");
      wr(A_STAT, 32'h13);

      // R9 overflow and R12 interrupt routing
      wr(A_INTEN, 32'h10 | (3 << 8));
      for (int k = 0; k < 9; k++) begin
         run(1, 1); run(0, 1);
      end
      run(0, 30);
      rd(A_STAT, d);
      chk("R9 count full", cnt_of(d), DEP);
      chk("R9 overflow", 32'(d[0]), 1);
      chk("R10 available", 32'(d[4]), 1);
      chk("R12 irq da", 32'(irq), 1);
      wr(A_INTEN, 0);
      chk("R12 irq masked", 32'(irq), 0);
      wr(A_INTEN, 32'h1);
      chk("R12 irq ovf", 32'(irq), 1);
      wr(A_INTEN, 32'h2);
      chk("R12 irq pe", 32'(irq), 1);
      wr(A_INTEN, 0);
      for (int k = 0; k < 8; k++) begin
         exp_q.push_back(32'h80);
         exp_q.push_back(0);
      end
      drain("R8 full contents");
      rd(A_FIFO, d); chk("R8 empty read", d, 0);
      rd(A_STAT, d); chk("R8 empty count", cnt_of(d), 0);
      wr(A_STAT, 32'h01);
      rd(A_STAT, d);
      chk("R11 ovf cleared", 32'(d[0]), 0);
      chk("R11 pe kept", 32'(d[1]), 1);
      wr(A_STAT, 32'h12);
      rd(A_STAT, d); chk("R11 all clear", d, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule